// File: doc/BRIEF.md
# LCD raster timing generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe, and the 0-based column and row of the pixel currently in the active area. A clock divider derives a pixel-rate enable from the source clock. A divide-enable bit selects between the programmed ratio and undivided 1:1 operation. Each direction is built from four programmed regions: sync pulse, back porch, active area and front porch. Every region length and the divider ratio are stored as the real value minus one.

A frame event is raised on the first pixel of the vertical sync pulse. It sets a pending bit when the frame source selects vsync and the frame enable is set. The interrupt line is driven only while the global enable is also set. The pending bit clears when a one is written to it. Sync polarity is a static configuration input. Output generation runs only while the video enable is set. When it is clear, the counters return to the first sync pixel and every output becomes inactive.

Top module: `lcd_raster_timing`

## Requirements
- R1: With `clkDivEn` low a pixel tick (`pixTick` high) occurs on every clock. With it high, ticks are spaced `clkDivM1`+1 clocks apart, up to 256.
- R2: Each line is `hSpwM1`+1 sync ticks, then `hBpM1`+1 back-porch ticks, then `hActM1`+1 active ticks, then `hFpM1`+1 front-porch ticks, and then it repeats.
- R3: Each frame is `vSpwM1`+1 sync lines, then `vBpM1`+1 back-porch lines, then `vActM1`+1 active lines, then `vFpM1`+1 front-porch lines. The line count advances at the end of each line.
- R4: `de` is high only where the horizontal and vertical active regions overlap. There, `pixX` and `pixY` count from 0 at the top-left active pixel. Outside the active area both are 0.
- R5: A sync pin is high while its pulse is active when its polarity input is 1, and low while active when the input is 0. When not active, the pin takes the opposite level.
- R6: While `vidEn` is low, no ticks occur, `de`, `pixX` and `pixY` are 0, and both syncs are inactive. After `vidEn` rises, the first tick is the first hsync pixel of the first vsync line.
- R7: `pendFrame` sets on the first pixel of each frame (the start of vsync) only if `frameIntEn` is 1 and `frameSrc` is 1 (vsync). `frameSrc` 0 (none) never sets it.
- R8: `irq` is high exactly when `pendFrame` and `intEn` are both high.
- R9: A one on `pendClr` clears `pendFrame` at the next clock edge. If a frame event happens on the same edge, the set takes priority.
- R10: After reset, `pixTick`, `de`, `pixX`, `pixY`, `pendFrame` and `irq` are 0, and both syncs are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low reset |
| vidEn | input | 1 | Video enable |
| hsyncPol | input | 1 | 1 = hsync active high |
| vsyncPol | input | 1 | 1 = vsync active high |
| hSpwM1 | input | PORCH_W | Hsync width minus one (ticks) |
| hBpM1 | input | PORCH_W | Horizontal back porch minus one |
| hActM1 | input | ACT_W | Active pixels per line minus one |
| hFpM1 | input | PORCH_W | Horizontal front porch minus one |
| vSpwM1 | input | PORCH_W | Vsync width minus one (lines) |
| vBpM1 | input | PORCH_W | Vertical back porch minus one |
| vActM1 | input | ACT_W | Active lines minus one |
| vFpM1 | input | PORCH_W | Vertical front porch minus one |
| clkDivEn | input | 1 | Divide enable; 0 selects 1:1 |
| clkDivM1 | input | DIV_W | Divide ratio minus one |
| intEn | input | 1 | Global interrupt enable |
| frameIntEn | input | 1 | Frame interrupt enable |
| frameSrc | input | 2 | Frame event source: 0 none, 1 vsync |
| pendClr | input | 1 | Write-one-to-clear for the pending bit |
| pixTick | output | 1 | Marks a clock carrying a new pixel |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| de | output | 1 | Data enable |
| pixX | output | ACT_W | Active column |
| pixY | output | ACT_W | Active row |
| pendFrame | output | 1 | Frame pending bit |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear write that lands on the same clock edge as a frame event, where the set must win. The frame-start edge is normally buried deep inside a frame. The bench makes it predictable: with the divider bypassed and video disabled, the counters rest on the first sync pixel, so the first edge after `vidEn` rises is a frame start. The bench raises `vidEn` and `pendClr` in the same cycle to force the collision. The region orderings are covered by sweeping a set of small configurations across divider, polarity and source settings. Each pixel of two whole frames is compared against positions computed in the bench.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  typedef enum logic [1:0] {
    FSRC_NONE  = 2'd0,
    FSRC_VSYNC = 2'd1
  } frameSrc_e;

  // strobes from the control side to the output datapath
  typedef struct packed {
    logic pixTick;
    logic hSyncOn;
    logic vSyncOn;
    logic hActive;
    logic vActive;
    logic frameStart;
  } rasterStrobes_t;

endpackage

// File: rtl/raster_axis.sv
module raster_axis #(
  parameter int PORCH_W = 8,
  parameter int ACT_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               adv,
  input  logic [PORCH_W-1:0] spwM1,
  input  logic [PORCH_W-1:0] bpM1,
  input  logic [ACT_W-1:0]   actM1,
  input  logic [PORCH_W-1:0] fpM1,
  output logic               syncOn,
  output logic               active,
  output logic               atFirst,
  output logic               atLast,
  output logic [ACT_W-1:0]   pos
);
  localparam int MAX_W = (ACT_W > PORCH_W) ? ACT_W : PORCH_W;
  localparam int CNT_W = MAX_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] syncEnd, actStart, actEnd, lastIdx;

  always_comb begin
    syncEnd  = CNT_W'(spwM1) + CNT_W'(1);
    actStart = syncEnd + CNT_W'(bpM1) + CNT_W'(1);
    actEnd   = actStart + CNT_W'(actM1) + CNT_W'(1);
    lastIdx  = actEnd + CNT_W'(fpM1);
    syncOn   = (cnt < syncEnd);
    active   = (cnt >= actStart) && (cnt < actEnd);
    atFirst  = (cnt == '0);
    // >= keeps a shrunk configuration from running the counter to overflow
    atLast   = (cnt >= lastIdx);
    pos      = ACT_W'(cnt - actStart);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (adv)    cnt <= atLast ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import lcd_timing_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int ACT_W   = 11,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vidEn,
  input  logic [PORCH_W-1:0] hSpwM1,
  input  logic [PORCH_W-1:0] hBpM1,
  input  logic [ACT_W-1:0]   hActM1,
  input  logic [PORCH_W-1:0] hFpM1,
  input  logic [PORCH_W-1:0] vSpwM1,
  input  logic [PORCH_W-1:0] vBpM1,
  input  logic [ACT_W-1:0]   vActM1,
  input  logic [PORCH_W-1:0] vFpM1,
  input  logic               clkDivEn,
  input  logic [DIV_W-1:0]   clkDivM1,
  output rasterStrobes_t     strb,
  output logic [ACT_W-1:0]   hPos,
  output logic [ACT_W-1:0]   vPos
);
  localparam int N_AXIS = 2;  // 0 = horizontal, 1 = vertical

  logic [DIV_W-1:0] divCnt;
  logic             divWrap, tick;

  assign divWrap = !clkDivEn || (divCnt >= clkDivM1);
  assign tick    = vidEn && divWrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       divCnt <= '0;
    else if (!vidEn)  divCnt <= '0;
    else if (divWrap) divCnt <= '0;
    else              divCnt <= divCnt + DIV_W'(1);
  end

  logic [PORCH_W-1:0] spwA [N_AXIS];
  logic [PORCH_W-1:0] bpA  [N_AXIS];
  logic [ACT_W-1:0]   actA [N_AXIS];
  logic [PORCH_W-1:0] fpA  [N_AXIS];
  logic               advA [N_AXIS];
  logic               syncA[N_AXIS];
  logic               actvA[N_AXIS];
  logic               firstA[N_AXIS];
  logic               lastA[N_AXIS];
  logic [ACT_W-1:0]   posA [N_AXIS];

  assign spwA[0] = hSpwM1;  assign spwA[1] = vSpwM1;
  assign bpA[0]  = hBpM1;   assign bpA[1]  = vBpM1;
  assign actA[0] = hActM1;  assign actA[1] = vActM1;
  assign fpA[0]  = hFpM1;   assign fpA[1]  = vFpM1;
  assign advA[0] = tick;
  assign advA[1] = tick && lastA[0];  // next line at end of line

  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    raster_axis #(.PORCH_W(PORCH_W), .ACT_W(ACT_W)) u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (vidEn),
      .adv    (advA[a]),
      .spwM1  (spwA[a]),
      .bpM1   (bpA[a]),
      .actM1  (actA[a]),
      .fpM1   (fpA[a]),
      .syncOn (syncA[a]),
      .active (actvA[a]),
      .atFirst(firstA[a]),
      .atLast (lastA[a]),
      .pos    (posA[a])
    );
  end

  always_comb begin
    strb.pixTick    = tick;
    strb.hSyncOn    = syncA[0];
    strb.vSyncOn    = syncA[1];
    strb.hActive    = actvA[0];
    strb.vActive    = actvA[1];
    strb.frameStart = tick && firstA[0] && firstA[1];
    hPos            = posA[0];
    vPos            = posA[1];
  end
endmodule

// File: rtl/raster_dp.sv
module raster_dp
  import lcd_timing_pkg::*;
#(
  parameter int ACT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vidEn,
  input  rasterStrobes_t   strb,
  input  logic [ACT_W-1:0] hPos,
  input  logic [ACT_W-1:0] vPos,
  input  logic             hsyncPol,
  input  logic             vsyncPol,
  input  logic             intEn,
  input  logic             frameIntEn,
  input  logic [1:0]       frameSrc,
  input  logic             pendClr,
  output logic             pixTick,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [ACT_W-1:0] pixX,
  output logic [ACT_W-1:0] pixY,
  output logic             pendFrame,
  output logic             irq
);
  logic hsAct, vsAct, deNow, setEv;

  assign deNow = strb.hActive && strb.vActive;
  assign setEv = strb.frameStart && frameIntEn && (frameSrc == FSRC_VSYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixTick   <= 1'b0;
      hsAct     <= 1'b0;
      vsAct     <= 1'b0;
      de        <= 1'b0;
      pixX      <= '0;
      pixY      <= '0;
      pendFrame <= 1'b0;
    end else begin
      // a frame event outranks a same-edge clear
      pendFrame <= setEv || (pendFrame && !pendClr);
      if (!vidEn) begin
        pixTick <= 1'b0;
        hsAct   <= 1'b0;
        vsAct   <= 1'b0;
        de      <= 1'b0;
        pixX    <= '0;
        pixY    <= '0;
      end else begin
        pixTick <= strb.pixTick;
        if (strb.pixTick) begin
          hsAct <= strb.hSyncOn;
          vsAct <= strb.vSyncOn;
          de    <= deNow;
          pixX  <= deNow ? hPos : '0;
          pixY  <= deNow ? vPos : '0;
        end
      end
    end
  end

  assign hsync = hsyncPol ? hsAct : !hsAct;
  assign vsync = vsyncPol ? vsAct : !vsAct;
  assign irq   = pendFrame && intEn;
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lcd_timing_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int ACT_W   = 11,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vidEn,
  input  logic               hsyncPol,
  input  logic               vsyncPol,
  input  logic [PORCH_W-1:0] hSpwM1,
  input  logic [PORCH_W-1:0] hBpM1,
  input  logic [ACT_W-1:0]   hActM1,
  input  logic [PORCH_W-1:0] hFpM1,
  input  logic [PORCH_W-1:0] vSpwM1,
  input  logic [PORCH_W-1:0] vBpM1,
  input  logic [ACT_W-1:0]   vActM1,
  input  logic [PORCH_W-1:0] vFpM1,
  input  logic               clkDivEn,
  input  logic [DIV_W-1:0]   clkDivM1,
  input  logic               intEn,
  input  logic               frameIntEn,
  input  logic [1:0]         frameSrc,
  input  logic               pendClr,
  output logic               pixTick,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [ACT_W-1:0]   pixX,
  output logic [ACT_W-1:0]   pixY,
  output logic               pendFrame,
  output logic               irq
);
  rasterStrobes_t   strb;
  logic [ACT_W-1:0] hPos, vPos;

  raster_ctrl #(.PORCH_W(PORCH_W), .ACT_W(ACT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .vidEn   (vidEn),
    .hSpwM1  (hSpwM1),
    .hBpM1   (hBpM1),
    .hActM1  (hActM1),
    .hFpM1   (hFpM1),
    .vSpwM1  (vSpwM1),
    .vBpM1   (vBpM1),
    .vActM1  (vActM1),
    .vFpM1   (vFpM1),
    .clkDivEn(clkDivEn),
    .clkDivM1(clkDivM1),
    .strb    (strb),
    .hPos    (hPos),
    .vPos    (vPos)
  );

  raster_dp #(.ACT_W(ACT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .vidEn     (vidEn),
    .strb      (strb),
    .hPos      (hPos),
    .vPos      (vPos),
    .hsyncPol  (hsyncPol),
    .vsyncPol  (vsyncPol),
    .intEn     (intEn),
    .frameIntEn(frameIntEn),
    .frameSrc  (frameSrc),
    .pendClr   (pendClr),
    .pixTick   (pixTick),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .pixX      (pixX),
    .pixY      (pixY),
    .pendFrame (pendFrame),
    .irq       (irq)
  );
endmodule

// File: rtl/raster_timing_checks.sv
module raster_timing_checks #(
  parameter int ACT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vidEn,
  input logic             hsyncPol,
  input logic             vsyncPol,
  input logic             clkDivEn,
  input logic             intEn,
  input logic             frameIntEn,
  input logic [1:0]       frameSrc,
  input logic             pendClr,
  input logic             pixTick,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [ACT_W-1:0] pixX,
  input logic [ACT_W-1:0] pixY,
  input logic             pendFrame,
  input logic             irq
);
  p_bypass_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vidEn && !clkDivEn) |=> pixTick);

  p_coords_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pixX == '0 && pixY == '0));

  p_idle_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vidEn |=> (hsync != hsyncPol && vsync != vsyncPol));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vidEn |=> (!pixTick && !de));

  p_pend_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendFrame) |-> $past(vidEn && frameIntEn && frameSrc == 2'd1));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (intEn && pendFrame));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pendClr && !vidEn) |=> !pendFrame);
endmodule

bind lcd_raster_timing raster_timing_checks #(.ACT_W(ACT_W)) u_chk (.*);

// File: tb/lcd_raster_timing_bench.sv
module lcd_raster_timing_bench;
  localparam int PORCH_W = 8;
  localparam int ACT_W   = 11;
  localparam int DIV_W   = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic vidEn = 0, hsyncPol = 0, vsyncPol = 0;
  logic [PORCH_W-1:0] hSpwM1 = 0, hBpM1 = 0, hFpM1 = 0, vSpwM1 = 0, vBpM1 = 0, vFpM1 = 0;
  logic [ACT_W-1:0]   hActM1 = 0, vActM1 = 0;
  logic clkDivEn = 0;
  logic [DIV_W-1:0] clkDivM1 = 0;
  logic intEn = 0, frameIntEn = 0, pendClr = 0;
  logic [1:0] frameSrc = 0;
  logic pixTick, hsync, vsync, de, pendFrame, irq;
  logic [ACT_W-1:0] pixX, pixY;

  lcd_raster_timing #(.PORCH_W(PORCH_W), .ACT_W(ACT_W), .DIV_W(DIV_W)) u_lcd_raster_timing (
    .clk(clk), .rst_n(rst_n), .vidEn(vidEn), .hsyncPol(hsyncPol), .vsyncPol(vsyncPol),
    .hSpwM1(hSpwM1), .hBpM1(hBpM1), .hActM1(hActM1), .hFpM1(hFpM1),
    .vSpwM1(vSpwM1), .vBpM1(vBpM1), .vActM1(vActM1), .vFpM1(vFpM1),
    .clkDivEn(clkDivEn), .clkDivM1(clkDivM1), .intEn(intEn), .frameIntEn(frameIntEn),
    .frameSrc(frameSrc), .pendClr(pendClr), .pixTick(pixTick), .hsync(hsync),
    .vsync(vsync), .de(de), .pixX(pixX), .pixY(pixY), .pendFrame(pendFrame), .irq(irq)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runCfg(int i);
    int hs, hb, ha, hf, vs, vb, va, vf, hTot, vTot, nPix, ratio, k, gap, h, v;
    bit hsA, vsA, deA, expPend;
    hSpwM1 = PORCH_W'(i % 3);   hBpM1 = PORCH_W'((i + 1) % 3);
    hActM1 = ACT_W'(2 + i % 4); hFpM1 = PORCH_W'(i % 2);
    vSpwM1 = PORCH_W'(i % 2);   vBpM1 = PORCH_W'((i / 2) % 3);
    vActM1 = ACT_W'(1 + i % 3); vFpM1 = PORCH_W'((i + 1) % 2);
    clkDivEn = i[0]; clkDivM1 = DIV_W'(i % 4);
    hsyncPol = i[1]; vsyncPol = i[2];
    intEn = (i % 4 != 3); frameIntEn = (i % 5 != 4);
    frameSrc = (i % 3 == 2) ? 2'd0 : 2'd1;
    vidEn = 0;
    @(negedge clk); pendClr = 1;
    @(negedge clk); pendClr = 0;
    @(negedge clk);
    chk("R6", "idle pixTick", pixTick, 0);
    chk("R6", "idle de", de, 0);
    chk("R9", "pending after clear", pendFrame, 0);
    hs = hSpwM1 + 1; hb = hBpM1 + 1; ha = hActM1 + 1; hf = hFpM1 + 1;
    vs = vSpwM1 + 1; vb = vBpM1 + 1; va = vActM1 + 1; vf = vFpM1 + 1;
    hTot = hs + hb + ha + hf; vTot = vs + vb + va + vf;
    nPix = 2 * hTot * vTot + 3;
    ratio = clkDivEn ? clkDivM1 + 1 : 1;
    expPend = 0; k = 0; gap = 0;
    vidEn = 1;
    while (k < nPix) begin
      @(negedge clk);
      gap++;
      if (pixTick) begin
        if (k > 0) chk("R1", "tick spacing", gap, ratio);
        gap = 0;
        h = k % hTot; v = (k / hTot) % vTot;
        hsA = (h < hs); vsA = (v < vs);
        deA = (h >= hs + hb) && (h < hs + hb + ha) && (v >= vs + vb) && (v < vs + vb + va);
        if (h == 0 && v == 0 && frameIntEn && frameSrc == 2'd1) expPend = 1;
        chk("R2,R5", "hsync", hsync, hsA ? hsyncPol : !hsyncPol);
        chk("R3,R5", "vsync", vsync, vsA ? vsyncPol : !vsyncPol);
        chk("R4", "de", de, deA);
        chk("R4", "pixX", pixX, deA ? h - hs - hb : 0);
        chk("R4", "pixY", pixY, deA ? v - vs - vb : 0);
        chk("R7", "pendFrame", pendFrame, expPend);
        chk("R8", "irq", irq, expPend && intEn);
        k++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int gap;
    hsyncPol = 1; vsyncPol = 0; intEn = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "pixTick", pixTick, 0);
    chk("R10", "hsync inactive", hsync, 0);
    chk("R10", "vsync inactive", vsync, 1);
    chk("R10", "de", de, 0);
    chk("R10", "pixX", pixX, 0);
    chk("R10", "pending", pendFrame, 0);
    chk("R10", "irq", irq, 0);

    for (int i = 0; i < 8; i++) runCfg(i);

    // R6: disable mid-frame, outputs go quiet
    vidEn = 0;
    repeat (10) begin
      @(negedge clk);
      chk("R6", "pixTick while disabled", pixTick, 0);
      chk("R6", "hsync while disabled", hsync, !hsyncPol);
      chk("R6", "pixY while disabled", pixY, 0);
    end

    // R1: largest divide ratio
    clkDivEn = 1; clkDivM1 = 8'd255;
    @(negedge clk); vidEn = 1;
    while (!pixTick) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!pixTick && gap < 400);
    chk("R1", "divide by 256 spacing", gap, 256);
    vidEn = 0;

    // R9: clear colliding with a frame event, set must win
    clkDivEn = 0; frameIntEn = 1; frameSrc = 2'd1; intEn = 1;
    @(negedge clk); pendClr = 1;
    @(negedge clk); pendClr = 0;
    @(negedge clk);
    chk("R9", "cleared before collision", pendFrame, 0);
    vidEn = 1; pendClr = 1;
    @(negedge clk); pendClr = 0; vidEn = 0;
    chk("R9", "set wins over clear", pendFrame, 1);
    chk("R8", "irq with pending", irq, 1);
    intEn = 0;
    @(negedge clk);
    chk("R8", "irq masked", irq, 0);
    pendClr = 1;
    @(negedge clk); pendClr = 0;
    chk("R9", "write-one clears", pendFrame, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule